// File: doc/BRIEF.md
# Event-Driven Two-Input Logic Network Evaluator

This block holds a small network of logic nodes in on-chip tables. Each node reads two bits of a shared state memory and writes one bit back. The function a node applies is set by a 4-bit truth-table code, so any of the 16 two-input functions can be chosen per node. There is no program counter and there are no fixed opcodes. Work is created only when a bit changes value. Every node that reads that bit is then queued, and evaluated later.

A single evaluator takes nodes from a first-in first-out queue one at a time. It reads the two operand bits and applies the node's code. When the result differs from the stored destination bit, it writes the result and walks that bit's dependent list. Each dependent that is not already waiting is pushed onto the queue. A change therefore spreads as a chain reaction until the network is stable. At that point the `idle` output rises.

An external write port changes state bits and starts propagation in the same way a node does. A separate load port fills the node, fanout, dependent and state tables while the block is idle. A combinational read port exposes any state bit.

Top module: `lnet_engine`

## Requirements
- R1: A node with inputs A (first operand) and B (second operand) outputs bit `code[3 - (2*A + B)]` of its 4-bit code. The most significant bit is the result for (0,0), then (0,1), then (1,0), and the least significant bit is the result for (1,1). So AND is 4'b0001, OR is 4'b0111 and exclusive-OR is 4'b0110.
- R2: Code 4'b0000 always yields 0 and code 4'b1111 always yields 1. Code 4'b0011 returns operand A and code 4'b0101 returns operand B.
- R3: A port write that changes a state bit queues every dependent of that bit. Propagation continues through the network until no bit changes, so a chain of nodes settles to the combinational value of its inputs.
- R4: A port write whose value equals the stored bit causes no evaluation. `idle` is still high on the falling edge that follows the accepting edge, and downstream bits are unchanged.
- R5: Dependents are queued only when a node's new value differs from the stored one. A changing write to a bit with one dependent, whose result does not change, shows `idle` low on exactly 4 falling edges after the accepting edge.
- R6: A node already waiting in the queue is not queued again. A changing write to a bit whose dependent list names the same unchanged-result node twice shows `idle` low on exactly 5 falling edges.
- R7: `idle` is high after reset and whenever the queue is empty with no evaluation or list walk in progress. It is low while any such work remains.
- R8: `wrReady` is low while an evaluation or list walk is in progress, or while the queue is full. It is high in the idle state.
- R9: Loads take effect only while `idle` is high, and a load to a state bit starts no propagation. `ldSel` selects the table:
  - 0 is a node entry at `ldAddr`, with `ldData[18:14]`=A index, `[13:9]`=B index, `[8:4]`=destination and `[3:0]`=code.
  - 1 is a fanout entry for bit `ldAddr`, with `ldData[5:0]`=start slot and `[12:6]`=count.
  - 2 is a dependent slot `ldAddr`, with `ldData[3:0]`=node.
  - 3 is state bit `ldAddr`, with value `ldData[0]`.
- R10: `rdData` shows state bit `rdAddr` combinationally, and all state bits read 0 after reset.
- R11: Nodes are evaluated in the order they were queued. When two nodes queued by the same change both drive one bit, the bit ends with the later node's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | External state write request |
| wrAddr | input | 5 | State bit index to write |
| wrData | input | 1 | Value to write |
| wrReady | output | 1 | Write accepted on this edge when high |
| ldEn | input | 1 | Table load strobe |
| ldSel | input | 2 | Table select (see R9) |
| ldAddr | input | 6 | Entry index for the load |
| ldData | input | 19 | Load data (layout per R9) |
| rdAddr | input | 5 | State bit index to read |
| rdData | output | 1 | Value of the addressed state bit |
| idle | output | 1 | Network settled: queue empty, evaluator free |

## Verification
Every network result is due on the first falling edge at which `idle` is high again after the accepting clock edge. The bench waits for that edge and only then has the scoreboard monitor read the expected bits through the combinational read port. The queue discipline is checked through exact settle lengths:
- An unchanged write holds `idle` high at once.
- A single unchanged-result dependent gives 4 low falling edges.
- A duplicated dependent gives 5 low falling edges.

Any extra or missing queue traffic shifts these counts. `wrReady` is sampled on the falling edge just after acceptance, when the walk state has begun.

// File: rtl/lnet_pkg.sv
package lnet_pkg;
  localparam int NUM_NODES = 16;
  localparam int NUM_BITS  = 32;
  localparam int DEP_SLOTS = 64;

  localparam int NODE_W  = $clog2(NUM_NODES);
  localparam int BIT_W   = $clog2(NUM_BITS);
  localparam int DEP_W   = $clog2(DEP_SLOTS);
  localparam int CNT_W   = DEP_W + 1;
  localparam int Q_DEPTH = NUM_NODES;

  localparam int ENTRY_W   = 3 * BIT_W + 4;
  localparam int FAN_W     = DEP_W + CNT_W;
  localparam int LD_DATA_W = (ENTRY_W > FAN_W) ? ENTRY_W : FAN_W;
  localparam int LD_ADDR_W = (DEP_W > BIT_W) ? ((DEP_W > NODE_W) ? DEP_W : NODE_W)
                                            : ((BIT_W > NODE_W) ? BIT_W : NODE_W);

  typedef struct packed {
    logic [BIT_W-1:0] srcA;
    logic [BIT_W-1:0] srcB;
    logic [BIT_W-1:0] dst;
    logic [3:0]       code;
  } node_t;

  typedef enum logic [1:0] {
    LD_NODE  = 2'd0,
    LD_FAN   = 2'd1,
    LD_DEP   = 2'd2,
    LD_STATE = 2'd3
  } ld_sel_e;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_EVAL  = 2'd1,
    ST_WALK  = 2'd2
  } eng_state_e;

  typedef struct packed {
    logic              stWr;
    logic [BIT_W-1:0]  bitSel;
    logic              stVal;
    logic              qPush;
    logic [NODE_W-1:0] pushNode;
    logic              qPop;
    logic [NODE_W-1:0] evalNode;
    logic [DEP_W-1:0]  depIdx;
  } strobe_t;
endpackage

// File: rtl/lnet_queue.sv
module lnet_queue #(
  parameter int W     = 4,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;

  assign head  = mem[rdPtr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wrPtr] <= pushData;
        wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (pop) rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !push);

  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !pop);
endmodule

// File: rtl/lnet_datapath.sv
module lnet_datapath
  import lnet_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic                 engIdle,
  input  logic                 ldEn,
  input  ld_sel_e              ldSel,
  input  logic [LD_ADDR_W-1:0] ldAddr,
  input  logic [LD_DATA_W-1:0] ldData,
  input  logic [BIT_W-1:0]     rdAddr,
  output logic                 rdData,
  output logic                 selBit,
  output logic [DEP_W-1:0]     selStart,
  output logic [CNT_W-1:0]     selCount,
  output logic [NODE_W-1:0]    depNode,
  output logic                 depPend,
  output logic [NODE_W-1:0]    headNode,
  output logic                 qEmpty,
  output logic                 qFull,
  output logic                 evalRes,
  output logic [BIT_W-1:0]     evalDst
);
  logic [NUM_BITS-1:0]  stateBits;
  logic [NUM_NODES-1:0] pending;
  node_t                nodeTab  [NUM_NODES];
  logic [DEP_W-1:0]     fanStart [NUM_BITS];
  logic [CNT_W-1:0]     fanCount [NUM_BITS];
  logic [NODE_W-1:0]    depTab   [DEP_SLOTS];

  logic  ldOk;
  node_t evalEntry;
  logic  opA, opB;

  assign ldOk = ldEn && engIdle;

  // lookups for the control
  assign rdData   = stateBits[rdAddr];
  assign selBit   = stateBits[strb.bitSel];
  assign selStart = fanStart[strb.bitSel];
  assign selCount = fanCount[strb.bitSel];
  assign depNode  = depTab[strb.depIdx];
  assign depPend  = pending[depNode];

  // node evaluation: MSB of the code answers (0,0), LSB answers (1,1)
  assign evalEntry = nodeTab[strb.evalNode];
  assign opA       = stateBits[evalEntry.srcA];
  assign opB       = stateBits[evalEntry.srcB];
  assign evalRes   = evalEntry.code[~{opA, opB}];
  assign evalDst   = evalEntry.dst;

  lnet_queue #(.W(NODE_W), .DEPTH(Q_DEPTH)) workQ (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strb.qPush),
    .pushData (strb.pushNode),
    .pop      (strb.qPop),
    .head     (headNode),
    .empty    (qEmpty),
    .full     (qFull)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateBits <= '0;
      pending   <= '0;
    end else begin
      if (ldOk && ldSel == LD_STATE) stateBits[ldAddr[BIT_W-1:0]] <= ldData[0];
      if (strb.stWr) stateBits[strb.bitSel] <= strb.stVal;
      if (strb.qPop)  pending[headNode] <= 1'b0;
      if (strb.qPush) pending[strb.pushNode] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_NODES; i++) nodeTab[i] <= '0;
      for (int i = 0; i < NUM_BITS; i++) begin
        fanStart[i] <= '0;
        fanCount[i] <= '0;
      end
      for (int i = 0; i < DEP_SLOTS; i++) depTab[i] <= '0;
    end else if (ldOk) begin
      unique case (ldSel)
        LD_NODE: nodeTab[ldAddr[NODE_W-1:0]] <= node_t'(ldData[ENTRY_W-1:0]);
        LD_FAN: begin
          fanStart[ldAddr[BIT_W-1:0]] <= ldData[DEP_W-1:0];
          fanCount[ldAddr[BIT_W-1:0]] <= ldData[FAN_W-1:DEP_W];
        end
        LD_DEP:  depTab[ldAddr[DEP_W-1:0]] <= ldData[NODE_W-1:0];
        default: ;
      endcase
    end
  end

  // R6
  no_dup_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.qPush |-> !pending[strb.pushNode]);

  // R9
  busy_load_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldEn && !engIdle && ldSel == LD_STATE && !strb.stWr) |=> $stable(stateBits));
endmodule

// File: rtl/lnet_control.sv
module lnet_control
  import lnet_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [BIT_W-1:0]  wrAddr,
  input  logic              wrData,
  input  logic              selBit,
  input  logic [DEP_W-1:0]  selStart,
  input  logic [CNT_W-1:0]  selCount,
  input  logic [NODE_W-1:0] depNode,
  input  logic              depPend,
  input  logic [NODE_W-1:0] headNode,
  input  logic              qEmpty,
  input  logic              qFull,
  input  logic              evalRes,
  input  logic [BIT_W-1:0]  evalDst,
  output strobe_t           strb,
  output logic              wrReady,
  output logic              idle
);
  eng_state_e        st;
  logic [NODE_W-1:0] curNode;
  logic [DEP_W-1:0]  walkPtr;
  logic [CNT_W-1:0]  walkCnt;

  logic accept, wrChanges, evalChanges, walkStep;

  assign wrReady     = (st == ST_READY) && !qFull;
  assign accept      = wrValid && wrReady;
  assign wrChanges   = accept && (wrData != selBit);
  assign evalChanges = (st == ST_EVAL) && (evalRes != selBit);
  assign walkStep    = (st == ST_WALK) && (walkCnt != '0) && (depPend || !qFull);
  assign idle        = (st == ST_READY) && qEmpty;

  always_comb begin
    strb          = '0;
    strb.evalNode = curNode;
    strb.depIdx   = walkPtr;
    strb.bitSel   = (st == ST_EVAL) ? evalDst : wrAddr;
    strb.pushNode = depNode;
    unique case (st)
      ST_READY: begin
        if (wrChanges) begin
          strb.stWr  = 1'b1;
          strb.stVal = wrData;
        end else if (!accept && !qEmpty) begin
          strb.qPop = 1'b1;
        end
      end
      ST_EVAL: begin
        if (evalChanges) begin
          strb.stWr  = 1'b1;
          strb.stVal = evalRes;
        end
      end
      ST_WALK: strb.qPush = walkStep && !depPend;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_READY;
      curNode <= '0;
      walkPtr <= '0;
      walkCnt <= '0;
    end else begin
      unique case (st)
        ST_READY: begin
          if (wrChanges) begin
            walkPtr <= selStart;
            walkCnt <= selCount;
            st      <= ST_WALK;
          end else if (!accept && !qEmpty) begin
            curNode <= headNode;
            st      <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (evalChanges) begin
            walkPtr <= selStart;
            walkCnt <= selCount;
            st      <= ST_WALK;
          end else begin
            st <= ST_READY;
          end
        end
        ST_WALK: begin
          if (walkCnt == '0) begin
            st <= ST_READY;
          end else if (walkStep) begin
            walkPtr <= walkPtr + 1'b1;
            walkCnt <= walkCnt - 1'b1;
          end
        end
        default: st <= ST_READY;
      endcase
    end
  end

  // R3
  dirty_write_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady && (wrData != selBit) && (selCount != '0)) |=> !idle);

  // R4
  same_write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady && (wrData == selBit) && qEmpty) |=> idle);

  // R8
  ready_only_settled_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> !$past(walkStep && walkCnt > CNT_W'(1)));
endmodule

// File: rtl/lnet_engine.sv
module lnet_engine
  import lnet_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrValid,
  input  logic [BIT_W-1:0]     wrAddr,
  input  logic                 wrData,
  output logic                 wrReady,
  input  logic                 ldEn,
  input  logic [1:0]           ldSel,
  input  logic [LD_ADDR_W-1:0] ldAddr,
  input  logic [LD_DATA_W-1:0] ldData,
  input  logic [BIT_W-1:0]     rdAddr,
  output logic                 rdData,
  output logic                 idle
);
  strob_wires: begin end
  strobe_t           strb;
  logic              selBit, depPend, qEmpty, qFull, evalRes;
  logic [DEP_W-1:0]  selStart;
  logic [CNT_W-1:0]  selCount;
  logic [NODE_W-1:0] depNode, headNode;
  logic [BIT_W-1:0]  evalDst;

  lnet_control ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrValid  (wrValid),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .selBit   (selBit),
    .selStart (selStart),
    .selCount (selCount),
    .depNode  (depNode),
    .depPend  (depPend),
    .headNode (headNode),
    .qEmpty   (qEmpty),
    .qFull    (qFull),
    .evalRes  (evalRes),
    .evalDst  (evalDst),
    .strb     (strb),
    .wrReady  (wrReady),
    .idle     (idle)
  );

  lnet_datapath dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .engIdle  (idle),
    .ldEn     (ldEn),
    .ldSel    (ld_sel_e'(ldSel)),
    .ldAddr   (ldAddr),
    .ldData   (ldData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .selBit   (selBit),
    .selStart (selStart),
    .selCount (selCount),
    .depNode  (depNode),
    .depPend  (depPend),
    .headNode (headNode),
    .qEmpty   (qEmpty),
    .qFull    (qFull),
    .evalRes  (evalRes),
    .evalDst  (evalDst)
  );
endmodule

// File: tb/lnet_engine_test.sv
module lnet_engine_test;
  import lnet_pkg::*;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 wrValid = 1'b0;
  logic [BIT_W-1:0]     wrAddr = '0;
  logic                 wrData = 1'b0;
  logic                 wrReady;
  logic                 ldEn = 1'b0;
  logic [1:0]           ldSel = '0;
  logic [LD_ADDR_W-1:0] ldAddr = '0;
  logic [LD_DATA_W-1:0] ldData = '0;
  logic [BIT_W-1:0]     rdAddr = '0;
  logic                 rdData;
  logic                 idle;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  typedef struct {
    int    addr;
    int    val;
    string req;
  } exp_t;
  exp_t expQ[$];
  event checkNow;

  always #5 clk = ~clk;

  lnet_engine uut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wrReady(wrReady), .ldEn(ldEn), .ldSel(ldSel), .ldAddr(ldAddr), .ldData(ldData),
    .rdAddr(rdAddr), .rdData(rdData), .idle(idle)
  );

  task automatic checkEq(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected bits and compares through the read port
  always begin
    @(checkNow);
    while (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      rdAddr = BIT_W'(e.addr);
      #1;
      checkEq(e.req, $sformatf("bit %0d", e.addr), int'(rdData), e.val);
    end
  end

  task automatic expectBit(int addr, int val, string req);
    exp_t e;
    e.addr = addr; e.val = val; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic settle();
    while (!idle) @(negedge clk);
  endtask

  task automatic runChecks();
    settle();
    -> checkNow;
    wait (expQ.size() == 0);
    #2;
  endtask

  task automatic load(int sel, int addr, int data);
    settle();
    ldEn = 1'b1; ldSel = 2'(sel); ldAddr = LD_ADDR_W'(addr); ldData = LD_DATA_W'(data);
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  task automatic loadNode(int idx, int a, int b, int d, int code);
    node_t n;
    n.srcA = BIT_W'(a); n.srcB = BIT_W'(b); n.dst = BIT_W'(d); n.code = 4'(code);
    load(0, idx, int'(n));
  endtask

  task automatic loadFan(int bitIdx, int start, int cnt);
    load(1, bitIdx, (cnt << DEP_W) | start);
  endtask

  // drives one write, returns ready sampled after acceptance and busy length
  task automatic wrBitCount(int addr, int val, output int rdyAfter, output int lowCnt);
    settle();
    wrValid = 1'b1; wrAddr = BIT_W'(addr); wrData = val[0];
    @(negedge clk);
    wrValid = 1'b0;
    rdyAfter = int'(wrReady);
    lowCnt = 0;
    while (!idle) begin
      lowCnt++;
      @(negedge clk);
    end
  endtask

  task automatic wrBit(int addr, int val);
    int r, c;
    wrBitCount(addr, val, r, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=settled");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rdy, cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state (R7, R8, R10)
    checkEq("R7", "idle after reset", int'(idle), 1);
    checkEq("R8", "wrReady after reset", int'(wrReady), 1);
    expectBit(9, 0, "R10");
    expectBit(31, 0, "R10");
    runChecks();

    // adder network: a=0 b=1 cin=2 x1=8 s=9 g=10 p=11 cout=12
    loadNode(0, 0, 1, 8, 4'b0110);
    loadNode(1, 8, 2, 9, 4'b0110);
    loadNode(2, 0, 1, 10, 4'b0001);
    loadNode(3, 8, 2, 11, 4'b0001);
    loadNode(4, 10, 11, 12, 4'b0111);
    load(2, 0, 0); load(2, 1, 2); load(2, 2, 1); load(2, 3, 3); load(2, 4, 4);
    loadFan(0, 0, 2); loadFan(1, 0, 2); loadFan(2, 2, 2); loadFan(8, 2, 2);
    loadFan(10, 4, 1); loadFan(11, 4, 1);
    // gate under test node 5: 16,17 -> 20
    load(2, 5, 5); loadFan(16, 5, 1); loadFan(17, 5, 1);
    // unchanged-result chain: node6 24,24->25 const0; node7 25->26
    loadNode(6, 24, 24, 25, 4'b0000);
    loadNode(7, 25, 25, 26, 4'b0011);
    load(2, 6, 6); load(2, 7, 7); loadFan(24, 6, 1); loadFan(25, 7, 1);
    // duplicate dependent: bit28 lists node8 twice
    loadNode(8, 28, 28, 29, 4'b0000);
    load(2, 8, 8); load(2, 9, 8); loadFan(28, 8, 2);
    // ordering: bit3 -> node9 (const1), node10 (const0), both drive bit4
    loadNode(9, 3, 3, 4, 4'b1111);
    loadNode(10, 3, 3, 4, 4'b0000);
    load(2, 10, 9); load(2, 11, 10); loadFan(3, 10, 2);

    // R1 / R2: sweep all 16 codes over a Gray sequence of inputs
    wrBit(16, 1);
    for (int code = 0; code < 16; code++) begin
      string tag;
      tag = (code == 0 || code == 15 || code == 3 || code == 5) ? "R2" : "R1";
      loadNode(5, 16, 17, 20, code);
      wrBit(16, 0); expectBit(20, (code >> 3) & 1, tag); runChecks();
      wrBit(17, 1); expectBit(20, (code >> 2) & 1, tag); runChecks();
      wrBit(16, 1); expectBit(20, (code >> 0) & 1, tag); runChecks();
      wrBit(17, 0); expectBit(20, (code >> 1) & 1, tag); runChecks();
    end

    // R3: full adder chain over all input patterns
    for (int v = 0; v < 8; v++) begin
      int a, b, c, sum;
      a = v & 1; b = (v >> 1) & 1; c = (v >> 2) & 1;
      sum = a + b + c;
      wrBit(0, a); wrBit(1, b); wrBit(2, c);
      expectBit(9, sum & 1, "R3");
      expectBit(12, sum >> 1, "R3");
      runChecks();
    end

    // R5, R8: one dependent whose result holds
    wrBitCount(24, 1, rdy, cnt);
    checkEq("R8", "wrReady during walk", rdy, 0);
    checkEq("R5", "settle length unchanged dependent", cnt, 4);
    checkEq("R7", "idle after settle", int'(idle), 1);
    expectBit(26, 0, "R5");
    runChecks();

    // R4: same value written again
    wrBitCount(24, 1, rdy, cnt);
    checkEq("R4", "busy cycles for same-value write", cnt, 0);
    checkEq("R4", "wrReady after same-value write", rdy, 1);
    expectBit(25, 0, "R4");
    runChecks();

    // R6: duplicated dependent queued once
    wrBitCount(28, 1, rdy, cnt);
    checkEq("R6", "settle length duplicate dependent", cnt, 5);

    // R11: queue order decides the final value
    wrBit(3, 1);
    expectBit(4, 0, "R11");
    runChecks();

    // R9: load while busy is dropped, load while idle lands without propagation
    settle();
    wrValid = 1'b1; wrAddr = BIT_W'(0); wrData = 1'b0;
    @(negedge clk);
    wrValid = 1'b0;
    checkEq("R7", "idle low while chain runs", int'(idle), 0);
    ldEn = 1'b1; ldSel = 2'd3; ldAddr = LD_ADDR_W'(30); ldData = LD_DATA_W'(1);
    @(negedge clk);
    ldEn = 1'b0;
    expectBit(30, 0, "R9");
    expectBit(9, 0, "R3");
    expectBit(12, 1, "R3");
    runChecks();
    load(3, 30, 1);
    checkEq("R9", "idle after state load", int'(idle), 1);
    expectBit(30, 1, "R9");
    load(3, 1, 0);
    expectBit(1, 0, "R9");
    expectBit(9, 0, "R9");
    runChecks();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule